// File: doc/BRIEF.md
# Serial Ones-Residue and Even-Zeros Detector

This block watches a bit-serial line and takes one bit per clock whenever its valid qualifier is high. It raises its detect output when two conditions hold together: the count of 1s taken so far is a multiple of three, and the count of 0s taken so far is even and greater than zero.

The block uses two small trackers side by side. One holds the count of 1s modulo three. The other sorts the count of 0s into three classes. Each tracker gives a flag, and the flags are ANDed to form the result. Between them the two trackers cover the nine combined states of a single composite machine.

A registered Moore-style output follows the state reached after each bit. An optional Mealy-style output flags, in the same cycle, the bit that leads into a qualifying state pair. Both tracker states are brought out for debug.

Top module: `serial_count_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is residue 0 (`dbg_ones` = 2'd0) and class "no zeros" (`dbg_zeros` = 2'b00). After such an edge, `det_moore` is 0, and `det_mealy` is 0 while `rst` is high.
- R2: When a valid bit equal to 1 is taken, the ones residue steps 0→1→2→0. `dbg_ones` shows the residue as a plain binary value 0, 1 or 2.
- R3: When a valid bit equal to 0 is taken, the zeros class moves from none to odd, from odd to even, and from even to odd. `dbg_zeros` encodes the classes as none = 2'b00, odd = 2'b01 and non-zero even = 2'b10.
- R4: When `in_valid` is low, neither tracker changes, whatever `in_bit` is, and `det_mealy` is 0.
- R5: One cycle after the edge that takes a bit, `det_moore` is 1 exactly when the residue is 0 and the zeros class is non-zero even.
- R6: With `MEALY_EN`=1, `det_mealy` is 1 during a cycle with `in_valid` high and `rst` low exactly when taking `in_bit` would lead into residue 0 with a non-zero even zeros class.
- R7: A synchronous reset wins over `in_valid`: a valid bit presented while `rst` is high is discarded.
- R8: A stream with no 0s never raises either output, even when its count of 1s is a multiple of three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_bit` in this cycle |
| in_bit | input | 1 | Serial data bit |
| det_moore | output | 1 | Registered detect output |
| det_mealy | output | 1 | Same-cycle detect output for the current bit |
| dbg_ones | output | 2 | Count of 1s modulo three |
| dbg_zeros | output | 2 | Zeros class: 00 none, 01 odd, 10 non-zero even |

## Verification
The bench goes after the first pair of 0s with no 1s, the case (0,2). A zeros tracker that mixed up "none" and "even" would flag the start of the stream or miss this first hit. It sends long runs of 1s with no 0s at all, which a design that treated zero zeros as even would wrongly flag. Valid-low cycles with a toggling data bit expose a tracker that ignores the qualifier. A reset asserted together with a valid bit shows whether reset takes priority. Random streams are checked against a count-based model, which catches a wrong residue wrap or a Mealy output that is one cycle off.

// File: rtl/det_pkg.sv
package det_pkg;

    localparam int ONES_MOD = 3;
    localparam int ONES_W   = $clog2(ONES_MOD);
    localparam int ZCLS_W   = 2;

    typedef enum logic [ONES_W-1:0] {
        ONES_R0 = 2'd0,
        ONES_R1 = 2'd1,
        ONES_R2 = 2'd2
    } ones_res_e;

    typedef enum logic [ZCLS_W-1:0] {
        ZC_NONE = 2'b00,
        ZC_ODD  = 2'b01,
        ZC_EVEN = 2'b10
    } zero_cls_e;

    function automatic ones_res_e ones_step(input ones_res_e cur);
        case (cur)
            ONES_R0: return ONES_R1;
            ONES_R1: return ONES_R2;
            default: return ONES_R0;
        endcase
    endfunction

    function automatic zero_cls_e zero_step(input zero_cls_e cur);
        return (cur == ZC_ODD) ? ZC_EVEN : ZC_ODD;
    endfunction

    function automatic logic pair_hit(input ones_res_e o, input zero_cls_e z);
        return (o == ONES_R0) && (z == ZC_EVEN);
    endfunction

endpackage

// File: rtl/ones_mod3_tracker.sv
module ones_mod3_tracker
    import det_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  logic      bit_in,
    output ones_res_e res_q,
    output ones_res_e res_nxt
);

    always_comb begin
        res_nxt = res_q;
        if (take && bit_in)
            res_nxt = ones_step(res_q);
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= ONES_R0;
        else     res_q <= res_nxt;
    end

    // R2
    ones_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (take && bit_in && res_q == ONES_R2) |=> (res_q == ONES_R0));

    // R4
    ones_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!take) |=> $stable(res_q));

endmodule

// File: rtl/zero_class_tracker.sv
module zero_class_tracker
    import det_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  logic      bit_in,
    output zero_cls_e cls_q,
    output zero_cls_e cls_nxt
);

    always_comb begin
        cls_nxt = cls_q;
        if (take && !bit_in)
            cls_nxt = zero_step(cls_q);
    end

    always_ff @(posedge clk) begin
        if (rst) cls_q <= ZC_NONE;
        else     cls_q <= cls_nxt;
    end

    // R3
    zero_leaves_none_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !bit_in) |=> (cls_q != ZC_NONE));

    // R3
    zero_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !bit_in && cls_q == ZC_EVEN) |=> (cls_q == ZC_ODD));

    // R4
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!take) |=> $stable(cls_q));

endmodule

// File: rtl/serial_count_detector.sv
module serial_count_detector
    import det_pkg::*;
#(
    parameter bit MEALY_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic              det_moore,
    output logic              det_mealy,
    output logic [ONES_W-1:0] dbg_ones,
    output logic [ZCLS_W-1:0] dbg_zeros
);

    ones_res_e ones_q, ones_nxt;
    zero_cls_e zero_q, zero_nxt;
    logic      hit_nxt;
    logic      moore_q;

    ones_mod3_tracker u_ones (
        .clk     (clk),
        .rst     (rst),
        .take    (in_valid),
        .bit_in  (in_bit),
        .res_q   (ones_q),
        .res_nxt (ones_nxt)
    );

    zero_class_tracker u_zero (
        .clk     (clk),
        .rst     (rst),
        .take    (in_valid),
        .bit_in  (in_bit),
        .cls_q   (zero_q),
        .cls_nxt (zero_nxt)
    );

    assign hit_nxt = pair_hit(ones_nxt, zero_nxt);

    always_ff @(posedge clk) begin
        if (rst) moore_q <= 1'b0;
        else     moore_q <= hit_nxt;
    end

    generate
        if (MEALY_EN) begin : g_mealy
            assign det_mealy = !rst && in_valid && hit_nxt;
        end else begin : g_no_mealy
            assign det_mealy = 1'b0;
        end
    endgenerate

    assign det_moore = moore_q;
    assign dbg_ones  = ones_q;
    assign dbg_zeros = zero_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ones_q == ONES_R0 && zero_q == ZC_NONE && !moore_q));

    // R5
    moore_pair_chk: assert property (@(posedge clk) disable iff (rst)
        det_moore == (ones_q == ONES_R0 && zero_q == ZC_EVEN));

    // R6
    mealy_leads_moore_chk: assert property (@(posedge clk) disable iff (rst)
        det_mealy |=> det_moore);

    // R8
    none_never_hits_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_q == ZC_NONE) |-> !det_moore);

    // R4
    mealy_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !det_mealy);

endmodule

// File: tb/serial_count_detector_bench.sv
module serial_count_detector_bench;

    logic clk = 1'b0;
    logic rst, in_valid, in_bit;
    logic det_moore, det_mealy;
    logic [1:0] dbg_ones, dbg_zeros;

    int n_tests = 0;
    int n_fail  = 0;
    int m_ones  = 0;
    int m_z     = 0;

    always #4 clk = ~clk;

    serial_count_detector u_serial_count_detector (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .det_moore (det_moore),
        .det_mealy (det_mealy),
        .dbg_ones  (dbg_ones),
        .dbg_zeros (dbg_zeros)
    );

    function automatic int nxt_ones(int o, logic v, logic b);
        return (v && b) ? (o + 1) % 3 : o;
    endfunction

    function automatic int nxt_z(int z, logic v, logic b);
        if (v && !b) return (z == 1) ? 2 : 1;
        return z;
    endfunction

    function automatic logic qual(int o, int z);
        return (o == 0) && (z == 2);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic r, logic v, logic b);
        logic exp_mealy;
        @(negedge clk);
        rst = r; in_valid = v; in_bit = b;
        #1;
        exp_mealy = !r && v && qual(nxt_ones(m_ones, v, b), nxt_z(m_z, v, b));
        chk("R6 mealy", det_mealy, exp_mealy);
        @(posedge clk);
        if (r) begin m_ones = 0; m_z = 0; end
        else begin
            m_ones = nxt_ones(m_ones, v, b);
            m_z    = nxt_z(m_z, v, b);
        end
        #1;
        chk("R5 moore", det_moore, qual(m_ones, m_z));
        chk("R2 ones", dbg_ones, m_ones);
        chk("R3 zeros", dbg_zeros, m_z);
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
        step(1, 0, 0);
        step(1, 1, 1);
        // R1 reset state
        chk("R1 ones", dbg_ones, 0);
        chk("R1 zeros", dbg_zeros, 0);
        chk("R1 moore", det_moore, 0);
        // (0,2)
        step(0, 1, 0);
        chk("R3 odd", dbg_zeros, 1);
        step(0, 1, 0);
        chk("R5 hit 0,2", det_moore, 1);
        // (3,2)
        step(0, 1, 1); step(0, 1, 1); step(0, 1, 1);
        chk("R5 hit 3,2", det_moore, 1);
        // R4 valid low with toggling bit
        for (int i = 0; i < 6; i++) begin
            step(0, 0, i[0]);
            chk("R4 hold ones", dbg_ones, 0);
            chk("R4 hold zeros", dbg_zeros, 2);
        end
        // (3,4)
        step(0, 1, 0); step(0, 1, 0);
        chk("R5 hit 3,4", det_moore, 1);
        // R7 reset with valid bit
        step(1, 1, 1);
        chk("R7 ones", dbg_ones, 0);
        chk("R7 zeros", dbg_zeros, 0);
        // R8 ones only
        for (int i = 0; i < 9; i++) begin
            step(0, 1, 1);
            chk("R8 no zeros moore", det_moore, 0);
        end
        step(1, 0, 0);
        // (6,2)
        for (int i = 0; i < 6; i++) step(0, 1, 1);
        step(0, 1, 0); step(0, 1, 0);
        chk("R5 hit 6,2", det_moore, 1);
        // random stream
        for (int i = 0; i < 4000; i++) begin
            logic r, v, b;
            r = ($urandom % 97) == 0;
            v = ($urandom % 4) != 0;
            b = $urandom % 2;
            step(r, v, b);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule